// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger Flags for a Two-Wire Serial Controller

This block sits between a register bus and the byte engine of a two-wire serial master. It holds one byte queue for outgoing data and one for incoming data, each sixteen entries deep. Software writes bytes for transmission and reads received bytes through a single data register. The engine takes outgoing bytes and delivers incoming ones over valid/ready handshakes. The serial protocol itself is not part of the block.

Each queue has a programmable fill threshold. When the threshold is crossed, a status flag is raised, and the flag can drive the interrupt line. The transmit-end flag is sticky. It stays set after the last byte has left, so the engine can hold the clock line low until software clears it. Flags are cleared by writing zero to the bit and left alone by writing one. Bad data-port accesses are absorbed and recorded in a sticky error bit.

Top module: `i2c_dual_fifo`

## Requirements
- R1: After reset, both occupancy counts read 0, the control register (offset 0) and the interrupt-enable register (offset 2) read 0, `irq` and `tx_end_hold` are low, `tx_valid` is low and `rx_ready` is high.
- R2: A write to the data register (offset 3) queues the byte for transmission. The engine receives queued bytes oldest first on `tx_data`, and each one leaves when `tx_valid` and `tx_ready` are both high. The transmit occupancy reads at offset 5.
- R3: A byte offered with `rx_valid` and `rx_ready` both high is stored. A read of offset 3 returns the oldest stored byte on `reg_rdata` one cycle later and removes it. The receive occupancy reads at offset 4.
- R4: Control bits [3:2] select the transmit threshold: code 0 selects 8, code 1 selects 4, code 2 selects 2 and code 3 selects 0 entries. Status bit 0 becomes set when the transmit occupancy is at or below the threshold.
- R5: Control bits [7:4] hold a value N. Status bit 1 becomes set when the receive occupancy is at least N+1.
- R6: Status bit 2 (transmit end) becomes set when the transmit queue is empty and `eng_idle` is high. It then stays set, and drives `tx_end_hold`, until software clears it, even after the queue refills or the engine leaves idle.
- R7: A write to the status register (offset 1) clears each bit written 0 and keeps each bit written 1. A flag whose setting condition still holds is set again on the next cycle.
- R8: A data write while the transmit queue is full is discarded. A data read while the receive queue is empty returns 0 and removes nothing. Either access sets the sticky status bit 3.
- R9: Writing 1 to control bit 0 empties the transmit queue, and writing 1 to control bit 1 empties the receive queue. These two bits read back as 0, while bits [7:2] read back as written.
- R10: `irq` is high exactly when some status bit among [2:0] is set and the matching interrupt-enable bit (offset 2, bits [2:0]) is set. It follows the flags by one cycle.
- R11: `rx_ready` is low while the receive queue holds 16 bytes, so an offered byte is not taken, and `tx_valid` is low while the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| tx_valid | output | 1 | Transmit byte available to the engine |
| tx_ready | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Receive queue can take a byte |
| rx_data | input | 8 | Received byte from the engine |
| eng_idle | input | 1 | Engine has finished shifting its last byte |
| tx_end_hold | output | 1 | Sticky transmit-end flag, used to stretch the clock |
| irq | output | 1 | Registered interrupt request |

## Verification
Occupancy, queue contents and the handshake outputs change at the clock edge of the access itself. A threshold or transmit-end flag follows the occupancy change by one edge, and `irq` follows the flag by one further edge. Register reads come back one edge after the strobe. Every stimulus is applied at a falling edge. The read task always lets one idle edge pass before issuing its strobe, so a flag raised by the preceding access is already registered when it is sampled. Interrupt checks wait two edges after the access that causes them, and the handshake outputs are sampled at the falling edge right after the access.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_IEN   = 3'd2,
    RA_DATA  = 3'd3,
    RA_RXCNT = 3'd4,
    RA_TXCNT = 3'd5
  } reg_addr_e;

  localparam int FL_TXLOW  = 0;
  localparam int FL_RXHIT  = 1;
  localparam int FL_TXEND  = 2;
  localparam int FL_ERR    = 3;
  localparam int NFLAG     = 4;
  localparam int NIRQ      = 3;
endpackage

// File: rtl/dfq_fifo.sv
module dfq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  qdata,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  // storage without reset so the array maps to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= pdata;
  end
  assign qdata = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R11: occupancy never exceeds the depth
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R8: a push into a full queue without a pop leaves the count unchanged
  a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (cnt == CW'(DEPTH)));
  // R2: an accepted lone push grows the count by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
    (push && !full && !pop && !flush) |=> (cnt == $past(cnt) + CW'(1)));
  // R9: flush empties the queue
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/dfq_trig.sv
module dfq_trig #(
  parameter int DEPTH = 16,
  localparam int NW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic [1:0]    tx_code,
  input  logic [NW-1:0] rx_n,
  output logic          tx_low,
  output logic          rx_hit
);
  localparam logic [CW-1:0] LVL_HALF   = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL_QUART  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL_EIGHTH = CW'(DEPTH / 8);

  logic [CW-1:0] tx_lvl;
  logic [CW-1:0] rx_need;

  always_comb begin
    case (tx_code)
      2'd0:    tx_lvl = LVL_HALF;
      2'd1:    tx_lvl = LVL_QUART;
      2'd2:    tx_lvl = LVL_EIGHTH;
      default: tx_lvl = '0;
    endcase
  end

  assign rx_need = {1'b0, rx_n} + CW'(1);
  assign tx_low  = (tx_cnt <= tx_lvl);
  assign rx_hit  = (rx_cnt >= rx_need);
endmodule

// File: rtl/i2c_dual_fifo.sv
module i2c_dual_fifo
  import dfq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int NW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              eng_idle,
  output logic              tx_end_hold,
  output logic              irq
);
  logic wr_ctrl, wr_stat, wr_ien, wr_data, rd_data;
  logic tx_flush, rx_flush;
  logic [1:0]       tx_code;
  logic [NW-1:0]    rx_n;
  logic [NIRQ-1:0]  ien;
  logic [NFLAG-1:0] flags, flag_set;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_q;
  logic             tx_low, rx_hit, err_set;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_ien  = reg_wr && (reg_addr == RA_IEN);
  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign rd_data = reg_rd && (reg_addr == RA_DATA);

  assign tx_flush = wr_ctrl && reg_wdata[0];
  assign rx_flush = wr_ctrl && reg_wdata[1];

  dfq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(wr_data), .pdata(reg_wdata),
    .pop(tx_ready), .qdata(tx_data),
    .cnt(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  dfq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_valid), .pdata(rx_data),
    .pop(rd_data), .qdata(rx_q),
    .cnt(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  dfq_trig #(.DEPTH(DEPTH)) u_trig (
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_code(tx_code), .rx_n(rx_n),
    .tx_low(tx_low), .rx_hit(rx_hit)
  );

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_code <= '0;
      rx_n    <= '0;
      ien     <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_code <= reg_wdata[3:2];
        rx_n    <= reg_wdata[4 +: NW];
      end
      if (wr_ien) ien <= reg_wdata[NIRQ-1:0];
    end
  end

  // status flags: set by condition, cleared by writing zero
  assign err_set = (wr_data && tx_full) || (rd_data && rx_empty);

  always_comb begin
    flag_set           = '0;
    flag_set[FL_TXLOW] = tx_low;
    flag_set[FL_RXHIT] = rx_hit;
    flag_set[FL_TXEND] = tx_empty && eng_idle;
    flag_set[FL_ERR]   = err_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (wr_stat ? (flags & reg_wdata[NFLAG-1:0]) : flags) | flag_set;
      irq   <= |(flags[NIRQ-1:0] & ien);
    end
  end

  assign tx_end_hold = flags[FL_TXEND];

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= DATA_W'({rx_n, tx_code, 2'b00});
        RA_STAT:  reg_rdata <= DATA_W'(flags);
        RA_IEN:   reg_rdata <= DATA_W'(ien);
        RA_DATA:  reg_rdata <= rx_empty ? '0 : rx_q;
        RA_RXCNT: reg_rdata <= DATA_W'(rx_cnt);
        RA_TXCNT: reg_rdata <= DATA_W'(tx_cnt);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R6: transmit end persists until a status write clears it
  a_r6_tend_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_end_hold && !wr_stat) |=> tx_end_hold);
  // R8: error bit persists until a status write clears it
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[FL_ERR] && !wr_stat) |=> flags[FL_ERR]);
  // R10: no enabled flag means no interrupt on the next cycle
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
    ((flags[NIRQ-1:0] & ien) == '0) |=> !irq);
  // R10: an enabled flag raises the interrupt on the next cycle
  a_r10_irq_raised: assert property (@(posedge clk) disable iff (rst)
    ((flags[NIRQ-1:0] & ien) != '0) |=> irq);
  // R11: receive handshake refuses bytes when full
  a_r11_rx_full_block: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> !rx_ready);
endmodule

// File: tb/i2c_dual_fifo_tb.sv
module i2c_dual_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr, reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       rx_valid, rx_ready;
  logic [7:0] rx_data;
  logic       eng_idle, tx_end_hold, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_dual_fifo #(.DATA_W(8), .DEPTH(16)) u_dut (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_idle(eng_idle), .tx_end_hold(tx_end_hold), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    tick(1);
    reg_rd = 1'b1; reg_addr = a;
    tick(1);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic eng_pop(output logic [7:0] d);
    d = tx_data;
    tx_ready = 1'b1;
    tick(1);
    tx_ready = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    tick(1);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1", "irq", irq, 0);
    chk("R1", "tx_end_hold", tx_end_hold, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "rx_ready", rx_ready, 1);
    rd(3'd5, v); chk("R1", "txcnt", v, 0);
    rd(3'd4, v); chk("R1", "rxcnt", v, 0);
    rd(3'd0, v); chk("R1", "ctrl", v, 0);
    rd(3'd2, v); chk("R1", "ien", v, 0);
  endtask

  task automatic t_tx_path;
    logic [7:0] v, d;
    wr(3'd3, 8'h11); wr(3'd3, 8'h22); wr(3'd3, 8'h33);
    rd(3'd5, v); chk("R2", "txcnt after 3", v, 3);
    chk("R11", "tx_valid nonempty", tx_valid, 1);
    eng_pop(d); chk("R2", "byte0", d, 8'h11);
    eng_pop(d); chk("R2", "byte1", d, 8'h22);
    eng_pop(d); chk("R2", "byte2", d, 8'h33);
    chk("R11", "tx_valid empty", tx_valid, 0);
    rd(3'd5, v); chk("R2", "txcnt drained", v, 0);
  endtask

  task automatic t_tx_trig;
    logic [7:0] v, d;
    wr(3'd0, 8'h01);
    for (int i = 0; i < 9; i++) wr(3'd3, 8'(8'h40 + i));
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4", "code0 at 9", v[0], 0);
    eng_pop(d);
    rd(3'd1, v); chk("R4", "code0 at 8", v[0], 1);
    wr(3'd0, 8'h09);
    for (int i = 0; i < 3; i++) wr(3'd3, 8'(i));
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4", "code2 at 3", v[0], 0);
    eng_pop(d);
    rd(3'd1, v); chk("R4", "code2 at 2", v[0], 1);
    wr(3'd0, 8'h05);
    for (int i = 0; i < 5; i++) wr(3'd3, 8'(i));
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4", "code1 at 5", v[0], 0);
    eng_pop(d);
    rd(3'd1, v); chk("R4", "code1 at 4", v[0], 1);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R7", "cond holds, re-set", v[0], 1);
    wr(3'd0, 8'h0D);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4", "code3 at 0", v[0], 1);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R4", "code3 at 1", v[0], 0);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_rx_trig;
    logic [7:0] v;
    wr(3'd0, 8'h30);
    eng_push(8'hA0); eng_push(8'hA1); eng_push(8'hA2);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R5", "N=3 at 3", v[1], 0);
    eng_push(8'hA3);
    rd(3'd1, v); chk("R5", "N=3 at 4", v[1], 1);
    rd(3'd4, v); chk("R3", "rxcnt", v, 4);
    for (int i = 0; i < 4; i++) begin
      rd(3'd3, v); chk("R3", "rx order", v, 8'(8'hA0 + i));
    end
    rd(3'd4, v); chk("R3", "rxcnt drained", v, 0);
  endtask

  task automatic t_errors;
    logic [7:0] v, d;
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R8", "err clear", v[3], 0);
    rd(3'd3, v); chk("R8", "empty read data", v, 0);
    rd(3'd1, v); chk("R8", "err after empty read", v[3], 1);
    rd(3'd4, v); chk("R8", "rxcnt after empty read", v, 0);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R7", "err cleared by zero", v[3], 0);
    for (int i = 0; i < 16; i++) wr(3'd3, 8'(8'h80 + i));
    wr(3'd3, 8'hEE);
    rd(3'd5, v); chk("R8", "txcnt full", v, 16);
    rd(3'd1, v); chk("R8", "err after full write", v[3], 1);
    for (int i = 0; i < 16; i++) begin
      eng_pop(d); chk("R8", "full data intact", d, 8'(8'h80 + i));
    end
    chk("R8", "overflow byte absent", tx_valid, 0);
    for (int i = 0; i < 16; i++) eng_push(8'(8'hC0 + i));
    chk("R11", "rx_ready full", rx_ready, 0);
    eng_push(8'hDD);
    rd(3'd4, v); chk("R11", "rxcnt full", v, 16);
    rd(3'd3, v); chk("R3", "first of full", v, 8'hC0);
    chk("R11", "rx_ready after pop", rx_ready, 1);
    wr(3'd0, 8'h02);
    rd(3'd4, v); chk("R9", "rx flush", v, 0);
  endtask

  task automatic t_tx_end;
    logic [7:0] v;
    wr(3'd0, 8'h01);
    eng_idle = 1'b1;
    rd(3'd1, v); chk("R6", "tend set", v[2], 1);
    chk("R6", "tx_end_hold", tx_end_hold, 1);
    wr(3'd2, 8'h04);
    tick(2);
    chk("R10", "irq tend enabled", irq, 1);
    eng_idle = 1'b0;
    wr(3'd3, 8'h5A);
    rd(3'd1, v); chk("R6", "tend sticky", v[2], 1);
    wr(3'd1, 8'h04);
    rd(3'd1, v); chk("R7", "one keeps", v[2], 1);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R6", "tend cleared", v[2], 0);
    chk("R6", "hold cleared", tx_end_hold, 0);
    tick(2);
    chk("R10", "irq after clear", irq, 0);
    wr(3'd2, 8'h01);
    tick(2);
    chk("R10", "irq txlow", irq, 1);
    wr(3'd2, 8'h00);
    tick(2);
    chk("R10", "irq masked", irq, 0);
    wr(3'd0, 8'h01);
  endtask

  task automatic t_flush;
    logic [7:0] v;
    wr(3'd3, 8'h01); wr(3'd3, 8'h02);
    eng_push(8'h03); eng_push(8'h04);
    wr(3'd0, 8'h01);
    rd(3'd5, v); chk("R9", "tx flushed", v, 0);
    rd(3'd4, v); chk("R9", "rx untouched", v, 2);
    wr(3'd0, 8'h02);
    rd(3'd4, v); chk("R9", "rx flushed", v, 0);
    rd(3'd0, v); chk("R9", "ctrl reads 0", v, 0);
    wr(3'd0, 8'hF3);
    rd(3'd0, v); chk("R9", "ctrl fields", v, 8'hF0);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; eng_idle = 1'b0;
    @(negedge clk);
    tick(3);
    rst = 1'b0;
    t_reset();
    t_tx_path();
    t_tx_trig();
    t_rx_trig();
    t_errors();
    t_tx_end();
    t_flush();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule